// File: doc/BRIEF.md
# Windowed Light Alarm with Persistence Filter

This block watches the stream of light readings a converter publishes and decides when the light level has stayed outside a programmed window for long enough to warrant an alarm. Each reading arrives with a one-cycle valid pulse. Software supplies two 8-bit bounds. Each bound is widened into a 16-bit limit by placing the byte in the upper half and zeros in the lower half.

A two-bit persistence code sets how many consecutive out-of-window readings are needed before the alarm fires: 1, 4, 8 or 16. A single reading back inside the window starts the run again from zero. Once the alarm fires, it is sticky. It holds a status flag for the control register and an enable for an open-drain pull-down that drives the active-low interrupt line. It stays that way until the host clears it, either by writing zero to the flag bit or by pulsing the clear strobe that comes from the address byte of a bus write.

Top module: `lux_window_alarm`

## Requirements
- R1: The upper limit is {thr_hi_byte, 8'h00}. A reading equal to that value is inside the window, and a reading one count above it is outside.
- R2: The lower limit is {thr_lo_byte, 8'h00}. A reading equal to that value is inside the window, and a reading one count below it is outside.
- R3: persist_sel values 2'b00, 2'b01, 2'b10 and 2'b11 require 1, 4, 8 and 16 consecutive outside readings. The flag rises on the qualifying reading and not one reading earlier.
- R4: An inside reading presented with sample_valid resets the run of consecutive outside readings to zero.
- R5: alarm_flag and int_pull_en change on the same clock edge as the qualifying sample and are always equal (1 = flag set, line pulled low).
- R6: Once set, the flag stays set through any number of inside or outside readings until a clear request.
- R7: A flag write (flag_wr = 1) with flag_wdata = 0 clears the flag. A flag write with flag_wdata = 1 changes nothing, whether the flag is set or clear.
- R8: A one-cycle pulse on clr_strobe clears the flag.
- R9: A clear request also resets the run, so a fresh full run is needed to set the flag again.
- R10: When a clear request and a qualifying sample arrive in the same cycle, the clear wins: the flag is 0 afterwards and the run is 0.
- R11: sample_data is ignored in any cycle without sample_valid, and such cycles neither advance nor reset the run.
- R12: During and right after reset, alarm_flag and int_pull_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle pulse marking a new reading |
| sample_data | input | 16 | Newly published reading |
| thr_hi_byte | input | 8 | Upper bound, upper byte of the limit |
| thr_lo_byte | input | 8 | Lower bound, upper byte of the limit |
| persist_sel | input | 2 | Persistence code (1/4/8/16 readings) |
| flag_wr | input | 1 | Write strobe for the flag bit |
| flag_wdata | input | 1 | Value written to the flag bit |
| clr_strobe | input | 1 | One-cycle clear request |
| alarm_flag | output | 1 | Sticky alarm status bit |
| int_pull_en | output | 1 | Enable for the open-drain pull-down on the interrupt line |

## Verification
A wrong run count stays hidden until the reading that should have fired the alarm. At that point the flag comes up one or more readings early or late, so the checks sit exactly at the N-1 and N readings for every persistence code. A run that is not zeroed on an inside reading or on a clear shows the same way, as an early flag on the next run. A flag or pin register that drifts apart, or loses its stickiness, is visible at the ports in the cycle right after the edge. The bench therefore compares both outputs against its own model after every clock.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  localparam int DATA_W  = 16;
  localparam int THR_W   = 8;
  localparam int PSEL_W  = 2;
  localparam int PAD_W   = DATA_W - THR_W;
  localparam int MAX_RUN = 1 << (1 << PSEL_W);
  localparam int RUN_W   = $clog2(MAX_RUN + 1);

  typedef logic [DATA_W-1:0] sample_t;
  typedef logic [THR_W-1:0]  thr_t;
  typedef logic [PSEL_W-1:0] psel_t;
  typedef logic [RUN_W-1:0]  run_t;

  // A bound byte becomes the upper part of a full-width limit.
  function automatic sample_t thr_to_bound(input thr_t b);
    return {b, {PAD_W{1'b0}}};
  endfunction

  // Code 0 -> 1 reading, otherwise 2^(code+1) readings.
  function automatic run_t run_needed(input psel_t c);
    if (c == '0) return run_t'(1);
    return run_t'(1) << (int'(c) + 1);
  endfunction

  // Saturating increment of the run length.
  function automatic run_t run_bump(input run_t r);
    return (r >= run_t'(MAX_RUN)) ? r : r + run_t'(1);
  endfunction
endpackage

// File: rtl/lwa_window_cmp.sv
module lwa_window_cmp
  import lwa_pkg::*;
(
  input  sample_t sample,
  input  thr_t    thr_hi,
  input  thr_t    thr_lo,
  output logic    outside
);
  sample_t hi_bound;
  sample_t lo_bound;
  logic    above_hi;
  logic    below_lo;

  always_comb begin
    hi_bound = thr_to_bound(thr_hi);
    lo_bound = thr_to_bound(thr_lo);
    above_hi = sample > hi_bound;
    below_lo = sample < lo_bound;
    outside  = above_hi | below_lo;
  end
endmodule

// File: rtl/lwa_run_ctr.sv
module lwa_run_ctr
  import lwa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_valid,
  input  logic  outside,
  input  logic  clear_req,
  input  psel_t persist_sel,
  output logic  run_met
);
  run_t run_q;
  run_t run_next;
  run_t need;
  run_t bumped;

  always_comb begin
    need   = run_needed(persist_sel);
    bumped = run_bump(run_q);
    if (clear_req)         run_next = '0;
    else if (!sample_valid) run_next = run_q;
    else if (outside)       run_next = bumped;
    else                    run_next = '0;
    run_met = sample_valid & outside & ~clear_req & (bumped >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_next;
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= run_t'(MAX_RUN)); // R3
  AST_RUN_ZERO_INWIN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !outside && !clear_req |=> run_q == '0); // R4
  AST_RUN_ZERO_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> run_q == '0); // R9
  AST_RUN_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid && !clear_req |=> $stable(run_q)); // R11
endmodule

// File: rtl/lwa_alarm_latch.sv
module lwa_alarm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clear_req,
  output logic flag_q,
  output logic pin_q
);
  logic flag_next;
  logic pin_next;

  always_comb begin
    flag_next = clear_req ? 1'b0 : (flag_q | set_evt);
    pin_next  = clear_req ? 1'b0 : (pin_q | set_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      flag_q <= flag_next;
      pin_q  <= pin_next;
    end
  end

  AST_PIN_TRACKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q == flag_q); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> !flag_q); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clear_req |=> flag_q); // R6
  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !set_evt |=> !flag_q); // R11
endmodule

// File: rtl/lux_window_alarm.sv
module lux_window_alarm
  import lwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_data,
  input  logic [THR_W-1:0]  thr_hi_byte,
  input  logic [THR_W-1:0]  thr_lo_byte,
  input  logic [PSEL_W-1:0] persist_sel,
  input  logic              flag_wr,
  input  logic              flag_wdata,
  input  logic              clr_strobe,
  output logic              alarm_flag,
  output logic              int_pull_en
);
  logic outside;
  logic clear_req;
  logic run_met;

  assign clear_req = clr_strobe | (flag_wr & ~flag_wdata);

  lwa_window_cmp u_cmp (
    .sample  (sample_data),
    .thr_hi  (thr_hi_byte),
    .thr_lo  (thr_lo_byte),
    .outside (outside)
  );

  lwa_run_ctr u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .outside      (outside),
    .clear_req    (clear_req),
    .persist_sel  (persist_sel),
    .run_met      (run_met)
  );

  lwa_alarm_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (run_met),
    .clear_req (clear_req),
    .flag_q    (alarm_flag),
    .pin_q     (int_pull_en)
  );

  AST_SET_ON_MET: assert property (@(posedge clk) disable iff (!rst_n)
    run_met |=> alarm_flag); // R3
  AST_WRITE_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_flag && flag_wr && flag_wdata && !clr_strobe && !sample_valid |=> !alarm_flag); // R7
  AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_strobe |=> !alarm_flag && !int_pull_en); // R8
endmodule

// File: tb/lux_window_alarm_tb.sv
module lux_window_alarm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [15:0] sample_data = '0;
  logic [7:0]  thr_hi_byte = 8'hFF;
  logic [7:0]  thr_lo_byte = 8'h00;
  logic [1:0]  persist_sel = 2'b00;
  logic        flag_wr = 1'b0;
  logic        flag_wdata = 1'b0;
  logic        clr_strobe = 1'b0;
  logic        alarm_flag;
  logic        int_pull_en;

  int checks = 0;
  int fails = 0;
  int m_run = 0;
  logic m_flag = 1'b0;

  always #10 clk = ~clk;

  lux_window_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
    .thr_hi_byte(thr_hi_byte), .thr_lo_byte(thr_lo_byte), .persist_sel(persist_sel),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .clr_strobe(clr_strobe),
    .alarm_flag(alarm_flag), .int_pull_en(int_pull_en)
  );

  function automatic int needed(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit is_out(input int d, input int hi, input int lo);
    return (d > hi * 256) || (d < lo * 256);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input logic v, input int d, input logic fw, input logic fwd,
                      input logic cs, input string tag);
    sample_valid = v; sample_data = d[15:0];
    flag_wr = fw; flag_wdata = fwd; clr_strobe = cs;
    @(posedge clk);
    if (cs || (fw && !fwd)) begin
      m_run = 0; m_flag = 1'b0;
    end else if (v) begin
      if (is_out(d, int'(thr_hi_byte), int'(thr_lo_byte))) begin
        if (m_run < 16) m_run++;
        if (m_run >= needed(persist_sel)) m_flag = 1'b1;
      end else m_run = 0;
    end
    @(negedge clk);
    sample_valid = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0; clr_strobe = 1'b0;
    check({tag, " flag"}, alarm_flag, m_flag);
    check({tag, " pin (R5)"}, int_pull_en, m_flag);
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0, 1, "R8 clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R12: reset holds outputs low even with an outside sample presented
    @(negedge clk);
    sample_valid = 1'b1; sample_data = 16'hFFFF;
    @(negedge clk);
    check("R12 flag in reset", alarm_flag, 1'b0);
    check("R12 pin in reset", int_pull_en, 1'b0);
    sample_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 flag after reset", alarm_flag, 1'b0);
    check("R12 pin after reset", int_pull_en, 1'b0);

    // Default window FF00h/0000h: only readings above FF00h are outside
    step(1, 16'hFF00, 0, 0, 0, "R1 default hi equal");
    step(1, 16'hFF01, 0, 0, 0, "R1 default hi plus one");
    check("R1 default window fires", alarm_flag, 1'b1);
    clear_all();

    // R1: upper bound edge
    thr_hi_byte = 8'h40; thr_lo_byte = 8'h10; persist_sel = 2'b00;
    step(1, 16'h4000, 0, 0, 0, "R1 equal hi");
    check("R1 equal hi inside", alarm_flag, 1'b0);
    step(1, 16'h4001, 0, 0, 0, "R1 hi plus one");
    check("R1 hi plus one outside", alarm_flag, 1'b1);
    // R7: writing one leaves a set flag set
    step(0, 0, 1, 1, 0, "R7 write one while set");
    check("R7 write one keeps flag", alarm_flag, 1'b1);
    step(0, 0, 1, 0, 0, "R7 write zero clears");
    check("R7 write zero", alarm_flag, 1'b0);
    step(0, 0, 1, 1, 0, "R7 write one while clear");
    check("R7 write one no set", alarm_flag, 1'b0);

    // R2: lower bound edge
    step(1, 16'h1000, 0, 0, 0, "R2 equal lo");
    check("R2 equal lo inside", alarm_flag, 1'b0);
    step(1, 16'h0FFF, 0, 0, 0, "R2 lo minus one");
    check("R2 lo minus one outside", alarm_flag, 1'b1);
    // R6: stays set through inside readings
    for (int i = 0; i < 5; i++) step(1, 16'h2000, 0, 0, 0, "R6 sticky");
    check("R6 sticky after inside readings", alarm_flag, 1'b1);
    step(0, 0, 0, 0, 1, "R8 strobe");
    check("R8 strobe clears", alarm_flag, 1'b0);

    // R3: every persistence code, N-1 then N
    for (int c = 0; c < 4; c++) begin
      persist_sel = 2'(c);
      for (int i = 0; i < needed(2'(c)) - 1; i++) step(1, 16'h5000, 0, 0, 0, "R3 run");
      check($sformatf("R3 code %0d one short", c), alarm_flag, 1'b0);
      step(1, 16'h5000, 0, 0, 0, "R3 last");
      check($sformatf("R3 code %0d fires", c), alarm_flag, 1'b1);
      clear_all();
    end

    // R4: inside reading restarts the run
    persist_sel = 2'b01;
    for (int i = 0; i < 3; i++) step(1, 16'h0500, 0, 0, 0, "R4 run");
    step(1, 16'h3000, 0, 0, 0, "R4 inside");
    for (int i = 0; i < 3; i++) step(1, 16'h0500, 0, 0, 0, "R4 rerun");
    check("R4 no early fire", alarm_flag, 1'b0);
    step(1, 16'h0500, 0, 0, 0, "R4 fourth");
    check("R4 fires after fresh run", alarm_flag, 1'b1);
    clear_all();

    // R9: clear restarts the run
    for (int i = 0; i < 3; i++) step(1, 16'h8000, 0, 0, 0, "R9 run");
    step(0, 0, 0, 0, 1, "R9 clear mid run");
    for (int i = 0; i < 3; i++) step(1, 16'h8000, 0, 0, 0, "R9 rerun");
    check("R9 no early fire", alarm_flag, 1'b0);
    step(1, 16'h8000, 0, 0, 0, "R9 fourth");
    check("R9 fires after fresh run", alarm_flag, 1'b1);
    clear_all();

    // R10: simultaneous clear and qualifying sample
    persist_sel = 2'b00;
    step(1, 16'h8000, 0, 0, 1, "R10 strobe with sample");
    check("R10 clear wins strobe", alarm_flag, 1'b0);
    step(1, 16'h8000, 1, 0, 0, "R10 write zero with sample");
    check("R10 clear wins write", alarm_flag, 1'b0);

    // R11: data without valid is ignored
    for (int i = 0; i < 6; i++) step(0, 16'hFFFF, 0, 0, 0, "R11 no valid");
    check("R11 ignored", alarm_flag, 1'b0);
    persist_sel = 2'b01;
    for (int i = 0; i < 2; i++) step(1, 16'h8000, 0, 0, 0, "R11 run");
    for (int i = 0; i < 4; i++) step(0, 16'h2000, 0, 0, 0, "R11 gap");
    step(1, 16'h8000, 0, 0, 0, "R11 third");
    check("R11 gap held run short", alarm_flag, 1'b0);
    step(1, 16'h8000, 0, 0, 0, "R11 fourth");
    check("R11 gap kept run", alarm_flag, 1'b1);
    clear_all();

    // Random mix against the model (R1..R11)
    for (int n = 0; n < 4000; n++) begin
      int r, d, hi, lo;
      if ((n % 200) == 0) begin
        lo = int'($urandom_range(0, 120));
        hi = lo + int'($urandom_range(0, 135));
        thr_lo_byte = 8'(lo); thr_hi_byte = 8'(hi);
        persist_sel = 2'($urandom_range(0, 3));
      end
      r = int'($urandom_range(0, 9));
      if (r < 3)      d = int'(thr_hi_byte) * 256 + int'($urandom_range(0, 2)) - 1;
      else if (r < 5) d = int'(thr_lo_byte) * 256 + int'($urandom_range(0, 2)) - 1;
      else            d = int'($urandom_range(0, 65535));
      if (d < 0) d = 0;
      if (d > 65535) d = 65535;
      step($urandom_range(0, 3) != 0, d, $urandom_range(0, 40) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 60) == 0, "R3/R4/R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule